// File: doc/BRIEF.md
# Tick-rate clock multiplier

The block turns a slow tempo tick into a faster pulse train. The tick is already reduced to a strobe one system clock wide, for example one strobe per 1/24 of a quarter note. The output runs at a programmable multiple of the tick rate. A free-running period counter measures the number of system-clock cycles between successive ticks. Each measurement goes into an exponential moving average, which removes most of the tick-to-tick jitter. The averaged period is divided by the requested factor, and the quotient becomes the reload value of an output counter. That counter emits a single-cycle pulse each time it reaches the reload value.

Each accepted tick restarts the output counter and fires a pulse in the next cycle, so the output stays phase-aligned with the input. If the tick stream stops long enough for the period counter to saturate, the output goes quiet. It restarts only after two fresh ticks have been seen, because one fresh interval must be measured first. The loop is open: there is no phase detector, and the only correction is the restart on every tick.

Top module: `tick_mult`

## Requirements
- R1: While reset is asserted, and in every cycle until the second tick after reset has been accepted, `pulseOut` is 0.
- R2: The period sample is the number of clock cycles from one tick to the next. The first sample after the output was idle is loaded into the average directly.
- R3: Each later sample S updates the average A to A + floor((S - A) / 2^AVG_SHIFT), with the floor taken toward minus infinity. The default shift is 2.
- R4: The output spacing is floor(A / M) cycles, where M is `multSel`. A value of 0 for `multSel` is treated as 1, and the spacing is never less than 2 cycles.
- R5: Between ticks, the pulses on `pulseOut` are each exactly one cycle wide and are separated by the current spacing.
- R6: Each tick that finds the output running, or arming to run, restarts the output phase: `pulseOut` is 1 in the cycle after the tick is sampled. With a steady tick period T, the number of pulses from that cycle up to the next tick is floor((T - 2) / spacing) + 1.
- R7: The period counter saturates at 2^CNT_W - 1. Once it saturates without a tick, `pulseOut` stays 0. The next tick only re-arms the block, and pulses resume on the tick after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Input tempo strobe, one cycle wide |
| multSel | input | MULT_W | Multiplication factor (0 acts as 1) |
| pulseOut | output | 1 | Output pulse train, one cycle per pulse |

## Verification
The assertions take for granted that `tickIn` is high for one cycle per tick. They also assume that `multSel` holds steady near each tick, so that the spacing in force is the one computed from the latest average. The stimulus raises the strobe for exactly one cycle. It changes the factor only between windows, and it chooses tick gaps and factors that exercise exact floors, the minimum spacing, a factor of zero and a saturating silence. The per-cycle reference model also follows an irregular run of tick gaps, so jitter filtering is compared on every cycle.

// File: rtl/tick_mult_pkg.sv
package tick_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } trkState_t;

  typedef struct packed {
    logic restartCnt;
    logic seedAvg;
    logic updateAvg;
    logic restartOut;
    logic runEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/tick_mult_ctrl.sv
module tick_mult_ctrl
  import tick_mult_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tickIn,
  input  logic        satFlag,
  output ctrlStrobe_t strb,
  output logic        inRun
);

  trkState_t stateQ, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (tickIn) begin
          strb.restartCnt = 1'b1;
          stateNext       = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (tickIn) begin
          strb.restartCnt = 1'b1;
          if (!satFlag) begin
            strb.seedAvg    = 1'b1;
            strb.restartOut = 1'b1;
            stateNext       = ST_RUN;
          end
        end else if (satFlag) begin
          stateNext = ST_IDLE;
        end
      end
      ST_RUN: begin
        if (tickIn) begin
          strb.restartCnt = 1'b1;
          if (!satFlag) begin
            strb.updateAvg  = 1'b1;
            strb.restartOut = 1'b1;
          end else begin
            stateNext = ST_ARMED;
          end
        end else if (satFlag) begin
          stateNext = ST_IDLE;
        end else begin
          strb.runEn = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateNext;
  end

  assign inRun = (stateQ == ST_RUN);

endmodule

// File: rtl/tick_mult_dpath.sv
module tick_mult_dpath
  import tick_mult_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int MULT_W    = 7,
  parameter int AVG_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [MULT_W-1:0] multSel,
  output logic              satFlag,
  output logic [CNT_W-1:0]  sampleVal,
  output logic [CNT_W-1:0]  avgVal,
  output logic              pulseOut
);

  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] MIN_RELOAD = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] cntQ, avgQ, outCntQ;
  logic             pulseQ;
  logic signed [CNT_W:0] diffS, stepS;
  logic [CNT_W-1:0] avgNext, divisor, quot, reload;

  // period counter
  assign satFlag = (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)               cntQ <= '0;
    else if (strb.restartCnt) cntQ <= ONE;
    else if (!satFlag)        cntQ <= cntQ + ONE;
  end

  // smoothing filter
  assign diffS   = $signed({1'b0, cntQ}) - $signed({1'b0, avgQ});
  assign stepS   = diffS >>> AVG_SHIFT;
  assign avgNext = avgQ + stepS[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)              avgQ <= '0;
    else if (strb.seedAvg)   avgQ <= cntQ;
    else if (strb.updateAvg) avgQ <= avgNext;
  end

  // reload computation
  assign divisor = (multSel == '0) ? ONE : CNT_W'(multSel);
  assign quot    = avgQ / divisor;
  assign reload  = (quot < MIN_RELOAD) ? MIN_RELOAD : quot;

  // output counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outCntQ <= '0;
      pulseQ  <= 1'b0;
    end else if (strb.restartOut) begin
      outCntQ <= ONE;
      pulseQ  <= 1'b1;
    end else if (strb.runEn) begin
      if (outCntQ >= reload) begin
        outCntQ <= ONE;
        pulseQ  <= 1'b1;
      end else begin
        outCntQ <= outCntQ + ONE;
        pulseQ  <= 1'b0;
      end
    end else begin
      outCntQ <= '0;
      pulseQ  <= 1'b0;
    end
  end

  assign sampleVal = cntQ;
  assign avgVal    = avgQ;
  assign pulseOut  = pulseQ;

endmodule

// File: rtl/tick_mult.sv
module tick_mult
  import tick_mult_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int MULT_W    = 7,
  parameter int AVG_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickIn,
  input  logic [MULT_W-1:0] multSel,
  output logic              pulseOut
);

  ctrlStrobe_t      strb;
  logic             satFlag;
  logic             inRun;
  logic [CNT_W-1:0] sampleVal, avgVal;

  tick_mult_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tickIn  (tickIn),
    .satFlag (satFlag),
    .strb    (strb),
    .inRun   (inRun)
  );

  tick_mult_dpath #(
    .CNT_W     (CNT_W),
    .MULT_W    (MULT_W),
    .AVG_SHIFT (AVG_SHIFT)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .multSel   (multSel),
    .satFlag   (satFlag),
    .sampleVal (sampleVal),
    .avgVal    (avgVal),
    .pulseOut  (pulseOut)
  );

endmodule

// File: rtl/tick_mult_chk.sv
module tick_mult_chk
  import tick_mult_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tickIn,
  input logic             pulseOut,
  input logic             satFlag,
  input logic             inRun,
  input ctrlStrobe_t      strb,
  input logic [CNT_W-1:0] sampleVal,
  input logic [CNT_W-1:0] avgVal
);

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inRun && !strb.restartOut) |=> !pulseOut);

  assert_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restartCnt |=> (sampleVal == CNT_W'(1)));

  assert_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.seedAvg |=> (avgVal == $past(sampleVal)));

  assert_one_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseOut && !tickIn) |=> !pulseOut);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restartOut |=> pulseOut);

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (satFlag && !tickIn) |=> !pulseOut);

endmodule

bind tick_mult tick_mult_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tickIn    (tickIn),
  .pulseOut  (pulseOut),
  .satFlag   (satFlag),
  .inRun     (inRun),
  .strb      (strb),
  .sampleVal (sampleVal),
  .avgVal    (avgVal)
);

// File: tb/tick_mult_tb.sv
`timescale 1ns/1ps
module tick_mult_tb;

  localparam int CNT_W  = 12;
  localparam int MULT_W = 7;
  localparam int SHIFT  = 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tickIn = 1'b0;
  logic [MULT_W-1:0] multSel = '0;
  logic              pulseOut;

  int compared = 0;
  int mismatched = 0;
  int totPulses = 0;
  int lastWin = 0;
  bit firstHigh = 0;
  bit finished = 0;
  int cyc = 0;

  // reference model state
  int mState = 0;   // 0 idle, 1 armed, 2 running
  int mCnt = 0, mAvg = 0, mOut = 0;
  bit mPulse = 0;

  always #10 clk = ~clk;

  tick_mult #(.CNT_W(CNT_W), .MULT_W(MULT_W), .AVG_SHIFT(SHIFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .multSel(multSel), .pulseOut(pulseOut)
  );

  function automatic int spacing(int avg, int m);
    int d, r;
    d = (m == 0) ? 1 : m;
    r = avg / d;
    return (r < 2) ? 2 : r;
  endfunction

  function automatic int expCount(int n, int r);
    return (n - 2) / r + 1;
  endfunction

  always @(posedge clk) begin
    int r, nState, nAvg, nOut;
    bit sat, rs, run, nPulse;
    if (!rst_n) begin
      mState = 0; mCnt = 0; mAvg = 0; mOut = 0; mPulse = 0;
    end else begin
      sat = (mCnt == CMAX);
      r = spacing(mAvg, int'(multSel));
      rs = 0; run = 0; nState = mState; nAvg = mAvg;
      if (tickIn) begin
        if (mState == 0 || sat) nState = 1;
        else begin
          rs = 1;
          nAvg = (mState == 1) ? mCnt : mAvg + ((mCnt - mAvg) >>> SHIFT);
          nState = 2;
        end
      end else if (sat) nState = 0;
      else if (mState == 2) run = 1;
      if (rs) begin nOut = 1; nPulse = 1; end
      else if (run) begin
        if (mOut >= r) begin nOut = 1; nPulse = 1; end
        else begin nOut = mOut + 1; nPulse = 0; end
      end else begin nOut = 0; nPulse = 0; end
      if (tickIn) mCnt = 1; else if (!sat) mCnt = mCnt + 1;
      mState = nState; mAvg = nAvg; mOut = nOut; mPulse = nPulse;
    end
  end

  // per-cycle comparison against the model (R5 pulse shape and spacing)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (pulseOut !== mPulse) begin
        mismatched++;
        $display("FAIL R5 cycle %0d actual=%0d expected=%0d", cyc, pulseOut, mPulse);
      end
      if (pulseOut === 1'b1) totPulses++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tickGap(input int n);
    int startTot;
    @(negedge clk); #1 tickIn = 1'b1; startTot = totPulses;
    @(negedge clk); firstHigh = pulseOut; #1 tickIn = 1'b0;
    repeat (n - 2) @(negedge clk);
    #1 lastWin = totPulses - startTot;
  endtask

  task automatic idleWait(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int startTot;
    int seed;
    multSel = 7'd8;
    repeat (5) @(negedge clk);
    check(pulseOut === 1'b0, "R1 reset", pulseOut, 0);
    #1 rst_n = 1'b1;

    tickGap(640);                       // arms only
    check(lastWin == 0, "R1 first tick", lastWin, 0);
    tickGap(720);                       // seed 640 -> spacing 80
    check(lastWin == expCount(720, 80), "R2 seed", lastWin, expCount(720, 80));
    check(firstHigh == 1, "R6 align", firstHigh, 1);
    tickGap(561);                       // avg 660 -> spacing 82
    check(lastWin == expCount(561, 82), "R3 update", lastWin, expCount(561, 82));
    check(firstHigh == 1, "R6 restart", firstHigh, 1);
    multSel = 7'd1;
    tickGap(1272);                      // avg 635 (floor of -24.75)
    check(lastWin == expCount(1272, 635), "R3 floor", lastWin, expCount(1272, 635));
    multSel = 7'd100;
    tickGap(1000);                      // avg 794 -> spacing 7
    check(lastWin == expCount(1000, 7), "R4 divide", lastWin, expCount(1000, 7));
    multSel = 7'd0;
    tickGap(1000);                      // avg 845, factor 0 as 1
    check(lastWin == expCount(1000, 845), "R4 zero factor", lastWin, expCount(1000, 845));
    multSel = 7'd64;
    seed = 7;
    for (int i = 0; i < 20; i++) begin  // jittered gaps, model compare (R3)
      seed = (seed * 37 + 11) % 97;
      tickGap(600 + seed);
    end
    check(firstHigh == 1, "R6 jitter", firstHigh, 1);

    idleWait(4200);                     // period counter saturates
    startTot = totPulses;
    idleWait(500);
    check(totPulses - startTot == 0, "R7 stopped", totPulses - startTot, 0);
    multSel = 7'd127;
    tickGap(200);
    check(lastWin == 0, "R7 rearm", lastWin, 0);
    tickGap(200);                       // 200/127 -> clamp 2
    check(lastWin == expCount(200, 2), "R4 minimum", lastWin, expCount(200, 2));
    check(firstHigh == 1, "R7 resume", firstHigh, 1);
    tickGap(200);
    check(lastWin == expCount(200, 2), "R6 steady", lastWin, expCount(200, 2));
    idleWait(10);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule